// File: doc/BRIEF.md
# Three-Lane 7:1 Serializer Transmitter

This block turns a 21-bit parallel word into three serial lanes and one forwarded clock lane. A new word is taken on each falling edge of a pixel clock. The word is split into three 7-bit slices, and each slice is shifted out on its own lane, one bit per rising edge of a bit clock. The bit clock runs at exactly seven times the pixel rate and is phase-locked to the pixel clock. The clock lane repeats a 7-bit pattern, so its frequency matches the pixel clock and its edges mark where each serial frame sits.

Captured words pass into the fast domain through a holding register that stays unchanged for a whole pixel period. A phase counter in the fast domain loads that register into the shift registers once per frame, always at the same phase. An active-low shutdown input forces every output low and clears every register at once. After shutdown is released, the outputs stay quiet until the first load.

Top module: `tri_lane_serializer`

## Requirements
- R1: Lane `n` (n = 0, 1, 2) carries data bits `7n` to `7n+6` of the captured word, so lane 0 takes bits 0–6, lane 1 takes bits 7–13 and lane 2 takes bits 14–20.
- R2: Within a frame, bit position 0 is the lowest-numbered data bit of the lane's slice, and the bits follow in ascending order, one per bit-clock cycle.
- R3: The word sent is the value `dataIn` held at the falling edge of `pixClk`. A change to `dataIn` after that edge, including one present when the load happens, does not alter the frame.
- R4: Over bit positions 0 to 6 of every frame, `clkOut` shows 1,1,0,0,0,1,1. Its period is therefore one pixel period.
- R5: After shutdown is released, the bit-clock rising edges are counted from one. A load happens on every seventh edge (the 7th, 14th and so on). Position 0 of the loaded word is visible from that edge onward, and frames follow back to back with no gap.
- R6: While `shutdownN` is low, `serOut` and `clkOut` are 0, whatever the clocks and `dataIn` do.
- R7: After `shutdownN` rises, `serOut` and `clkOut` stay 0 until the first load of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pixClk | input | 1 | Pixel clock; `dataIn` is captured on its falling edge |
| bitClk | input | 1 | Bit clock at seven times the pixel rate, phase-locked to `pixClk` |
| shutdownN | input | 1 | Active-low shutdown; clears all state and forces the outputs low |
| dataIn | input | 21 | Parallel data word |
| serOut | output | 3 | Serial data, one bit per lane |
| clkOut | output | 1 | Forwarded clock lane, frame-aligned |

## Verification
The bench builds the block with its default three lanes of seven bits. This gives a frame of seven bit-clock cycles and a 21-bit word, so walking-one and alternating patterns can expose a misrouted lane or a reversed bit order. The pixel clock falls 7.5 ns before each load edge, so a deliberate change to `dataIn` in between can be held on the input while the load takes place. Shutdown is applied in the middle of a frame and released a known distance from a falling edge, which places the first load at a computable time.

// File: rtl/lane_ser_pkg.sv
`timescale 1ns/1ps
package lane_ser_pkg;
  // strobes from the frame control to the lane datapath
  typedef struct packed {
    logic load;    // transfer holding word into shift registers
    logic shift;   // advance shift registers by one bit
    logic enable;  // a full frame has been loaded since shutdown release
    logic clkBit;  // clock-lane level for the current bit position
  } serCtrl_t;
endpackage

// File: rtl/lane_ser_ctrl.sv
`timescale 1ns/1ps
module lane_ser_ctrl
  import lane_ser_pkg::*;
#(
  parameter int SLICE = 7,
  parameter logic [SLICE-1:0] CLK_PAT = 7'b1100011
) (
  input  logic     bitClk,
  input  logic     shutdownN,
  output serCtrl_t ctrl
);
  localparam int PW = (SLICE > 1) ? $clog2(SLICE) : 1;
  localparam logic [PW-1:0] LAST = PW'(SLICE - 1);

  logic [PW-1:0] phase;
  logic          active;

  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN) begin
      phase  <= '0;
      active <= 1'b0;
    end else begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
      if (phase == LAST) active <= 1'b1;
    end
  end

  always_comb begin
    ctrl.load   = (phase == LAST);
    ctrl.shift  = (phase != LAST);
    ctrl.enable = active;
    ctrl.clkBit = CLK_PAT[LAST - phase];
  end

  // R5: once running, every frame start follows a load strobe
  p_wrap_after_load_r5: assert property (@(posedge bitClk) disable iff (!shutdownN)
    (ctrl.enable && phase == '0) |-> $past(ctrl.load));

  // R4: the clock lane is high at bit position 0 of each frame
  p_clk_frame_start_r4: assert property (@(posedge bitClk) disable iff (!shutdownN)
    ctrl.load |=> (ctrl.clkBit && ctrl.enable));
endmodule

// File: rtl/lane_ser_datapath.sv
`timescale 1ns/1ps
module lane_ser_datapath
  import lane_ser_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SLICE = 7,
  localparam int WORD = LANES * SLICE
) (
  input  logic             pixClk,
  input  logic             bitClk,
  input  logic             shutdownN,
  input  logic [WORD-1:0]  dataIn,
  input  serCtrl_t         ctrl,
  output logic [LANES-1:0] serOut
);
  logic [WORD-1:0] holdWord;
  logic            unusedClkBit;

  assign unusedClkBit = ctrl.clkBit;

  // pixel-domain capture, stable for a whole pixel period
  always_ff @(negedge pixClk or negedge shutdownN) begin
    if (!shutdownN) holdWord <= '0;
    else            holdWord <= dataIn;
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [SLICE-1:0] shiftReg;

    always_ff @(posedge bitClk or negedge shutdownN) begin
      if (!shutdownN)      shiftReg <= '0;
      else if (ctrl.load)  shiftReg <= holdWord[lane*SLICE +: SLICE];
      else if (ctrl.shift) shiftReg <= {1'b0, shiftReg[SLICE-1:1]};
    end

    assign serOut[lane] = shutdownN & ctrl.enable & shiftReg[0];

    // R2: by the next load all upper bits of the frame have been shifted out
    p_frame_drained_r2: assert property (@(posedge bitClk) disable iff (!shutdownN)
      (ctrl.load && ctrl.enable) |-> (shiftReg[SLICE-1:1] == '0));
  end
endmodule

// File: rtl/tri_lane_serializer.sv
`timescale 1ns/1ps
module tri_lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SLICE = 7,
  localparam int WORD = LANES * SLICE
) (
  input  logic             pixClk,
  input  logic             bitClk,
  input  logic             shutdownN,
  input  logic [WORD-1:0]  dataIn,
  output logic [LANES-1:0] serOut,
  output logic             clkOut
);
  serCtrl_t ctrlBus;

  lane_ser_ctrl #(.SLICE(SLICE)) i_ctrl (
    .bitClk    (bitClk),
    .shutdownN (shutdownN),
    .ctrl      (ctrlBus)
  );

  lane_ser_datapath #(.LANES(LANES), .SLICE(SLICE)) i_datapath (
    .pixClk    (pixClk),
    .bitClk    (bitClk),
    .shutdownN (shutdownN),
    .dataIn    (dataIn),
    .ctrl      (ctrlBus),
    .serOut    (serOut)
  );

  assign clkOut = shutdownN & ctrlBus.enable & ctrlBus.clkBit;

  // R6 and R7: no output activity while shut down or before the first load
  always_comb begin
    if (!shutdownN || !ctrlBus.enable)
      p_quiet_r7: assert (serOut == '0 && clkOut == 1'b0);
  end
endmodule

// File: tb/test_tri_lane_serializer.sv
`timescale 1ns/1ps
module test_tri_lane_serializer;
  localparam int LANES = 3;
  localparam int SLICE = 7;
  localparam int WORD  = LANES * SLICE;
  localparam logic [SLICE-1:0] CLK_EXP = 7'b1100011; // bit p = level at position p

  logic             pixClk = 1'b0;
  logic             bitClk = 1'b0;
  logic             shutdownN = 1'b0;
  logic [WORD-1:0]  dataIn = '0;
  logic [LANES-1:0] serOut;
  logic             clkOut;

  int checks = 0;
  int failures = 0;
  logic [WORD-1:0] seq [8];

  tri_lane_serializer i_tri_lane_serializer (
    .pixClk(pixClk), .bitClk(bitClk), .shutdownN(shutdownN),
    .dataIn(dataIn), .serOut(serOut), .clkOut(clkOut)
  );

  // 200 MHz bit clock: rising edges at 5k+2.5 ns
  always #2.5 bitClk = ~bitClk;

  // pixel clock, 7 bit periods: rises at 35m+2.5, falls at 35m+20
  initial begin
    #2.5;
    forever begin
      pixClk = 1'b1; #17.5;
      pixClk = 1'b0; #17.5;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // shut down, then release 10 ns after a falling pixClk edge F (time F+10)
  task automatic startLink();
    shutdownN = 1'b0;
    @(negedge pixClk);
    #10;
    shutdownN = 1'b1;
  endtask

  // called at F+10; sends n words from seq and checks each frame
  task automatic runStream(input int n, input bit glitch, input string tag);
    logic [SLICE-1:0] gotLane [LANES];
    logic [SLICE-1:0] gotClk;
    dataIn = seq[0];
    #35; // F+45: position 0 of frame 0
    for (int j = 0; j < n; j++) begin
      dataIn = (j + 1 < n) ? seq[j+1] : '0;
      for (int p = 0; p < SLICE; p++) begin
        for (int l = 0; l < LANES; l++) gotLane[l][p] = serOut[l];
        gotClk[p] = clkOut;
        // after the capture edge and before the load edge: must not leak (R3)
        if (glitch && p == SLICE - 1) dataIn = ~dataIn;
        #5;
      end
      for (int l = 0; l < LANES; l++)
        check($sformatf("R1 R2 %s frame %0d lane %0d", tag, j, l),
              32'(gotLane[l]), 32'(seq[j][l*SLICE +: SLICE]));
      check($sformatf("R4 R5 %s clock lane frame %0d", tag, j), 32'(gotClk), 32'(CLK_EXP));
    end
  endtask

  task automatic testResetState();
    #20;
    check("R6 reset serOut", 32'(serOut), 32'd0);
    check("R6 reset clkOut", 32'(clkOut), 32'd0);
  endtask

  task automatic testMixedPatterns();
    seq[0] = 21'h1FFFFF; seq[1] = 21'h155555; seq[2] = 21'h0AAAAA;
    seq[3] = 21'h00007F; seq[4] = 21'h003F80; seq[5] = 21'h1FC000;
    startLink();
    runStream(6, 1'b0, "patterns");
  endtask

  task automatic testWalkingOne();
    for (int k = 0; k < 8; k++) seq[k] = WORD'(1) << (k * 3 % WORD);
    startLink();
    runStream(8, 1'b0, "walking");
  endtask

  task automatic testCaptureEdge();
    seq[0] = 21'h123456; seq[1] = 21'h0F0F0F; seq[2] = 21'h1C3870; seq[3] = 21'h000001;
    startLink();
    runStream(4, 1'b1, "R3 late change");
  endtask

  task automatic testShutdownMidFrame();
    startLink();
    dataIn = '1;
    #46; // F+56: position 2 of frame 0
    check("R1 ones before shutdown", 32'(serOut), 32'h7);
    #1;
    shutdownN = 1'b0;
    #1;
    check("R6 serOut after shutdown", 32'(serOut), 32'd0);
    check("R6 clkOut after shutdown", 32'(clkOut), 32'd0);
    #40;
    check("R6 serOut held low", 32'(serOut), 32'd0);
    check("R6 clkOut held low", 32'(clkOut), 32'd0);
  endtask

  task automatic testQuietAfterRelease();
    startLink();
    dataIn = '1;
    #30; // F+40: counter at position 6, no load yet
    check("R7 serOut before first load", 32'(serOut), 32'd0);
    check("R7 clkOut before first load", 32'(clkOut), 32'd0);
    #5;  // F+45: first load has happened
    check("R5 first frame serOut", 32'(serOut), 32'h7);
    check("R5 first frame clkOut", 32'(clkOut), 32'd1);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testResetState();
    testMixedPatterns();
    testWalkingOne();
    testCaptureEdge();
    testShutdownMidFrame();
    testQuietAfterRelease();
    #20;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule